// File: doc/BRIEF.md
# Dual-Bus External Program Fetch Sequencer

This block produces the pin-level sequence that fetches opcodes from external program memory for an 8-bit controller core that can reach code over either of two bus pairs: a primary pair (a multiplexed low-address/data port plus a high-address port) and an alternate pair with the same shape. A machine cycle is twelve oscillator clocks, split into two six-clock fetch slots. At the start of each slot the block samples the program counter, the bus-select pin and the external-access pin, and decides which bus, if any, serves that fetch. The decision can split the address map between the two buses.

Each slot raises the address latch enable for two clocks while the chosen bus drives the low address byte. It then drops the low-byte drive and pulls that bus's read strobe low for three clocks, and captures the opcode from the multiplexed port on the last strobe clock. When the core flags the machine cycle as a data-memory access, the second slot of that cycle carries no latch pulse and no strobe on either bus. The opcode output is a stream with a one-clock valid flag and no ready input: bus timing is fixed by the oscillator, so the consumer must take each byte in the clock it is offered.

Top module: `dual_fetch_seq`

## Requirements
- R1: While reset is held, the latch enable is 0, both read strobes are 1 (idle), both low-byte enables are 0 and the opcode valid flag is 0.
- R2: With bus-select 0 and external-access 0, every fetch uses the primary bus and the primary strobe, for any address from 0000h to FFFFh.
- R3: With bus-select 0 and external-access 1, no read strobe is asserted on either bus, no address is driven and no opcode is offered. The latch enable keeps pulsing.
- R4: With bus-select 1 and external-access 0, every fetch uses the alternate bus and the alternate strobe, over the whole 64 KB.
- R5: With bus-select 1 and external-access 1, addresses below 2000h are fetched over the alternate bus and addresses from 2000h up are fetched over the primary bus (1FFFh alternate, 2000h primary).
- R6: The serving bus drives the address high byte on its high port for the whole slot. It drives the low byte on its multiplexed port, with its enable at 1, exactly while the latch enable is high, and releases the enable in the clock the strobe falls. A bus that is not serving drives 00h on its high port and holds its enable at 0.
- R7: The byte present on the serving bus's multiplexed input during the last strobe clock appears on the opcode output, with the valid flag high for exactly one clock: the clock after the strobe ends.
- R8: A machine cycle holds two strobe pulses. When the data-memory flag was high at the start of the cycle, the second slot has no strobe on either bus.
- R9: The latch enable pulses once per six-clock slot. The pulse of the second slot is dropped in a machine cycle flagged as a data-memory access.
- R10: Each latch pulse is high for exactly 2 clocks, from clock 0 of the slot. Each strobe is low for exactly 3 clocks, slot clocks 2 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 16 | Fetch address, sampled at each slot start |
| bus_sel_i | input | 1 | Bus-select pin level |
| ext_acc_i | input | 1 | External-access pin level |
| xdata_cyc_i | input | 1 | Marks the starting machine cycle as a data-memory access |
| ale_o | output | 1 | Address latch enable |
| pri_rd_n_o | output | 1 | Primary program read strobe, active low |
| pri_hi_o | output | 8 | Primary high address port |
| pri_lo_o | output | 8 | Primary multiplexed port, low address out |
| pri_lo_oe_o | output | 1 | Primary multiplexed port drive enable |
| pri_lo_i | input | 8 | Primary multiplexed port, data in |
| alt_rd_n_o | output | 1 | Alternate program read strobe, active low |
| alt_hi_o | output | 8 | Alternate high address port |
| alt_lo_o | output | 8 | Alternate multiplexed port, low address out |
| alt_lo_oe_o | output | 1 | Alternate multiplexed port drive enable |
| alt_lo_i | input | 8 | Alternate multiplexed port, data in |
| op_valid_o | output | 1 | Opcode byte valid, one clock |
| op_data_o | output | 8 | Fetched opcode byte |

## Verification
The bench targets the split map at 1FFFh and 2000h, where an off-by-one compare would send a fetch down the wrong bus and read the wrong memory's byte. It also targets the invalid pin combination, where a faulty decoder would pulse a strobe no memory answers. Data-memory cycles are mixed in at random, because a design that drops the wrong slot, or keeps the latch pulse while skipping the strobe, shows a stray pulse in the second half of the cycle. The two memory models return different bytes, so an opcode taken from the wrong port or in the wrong clock fails the compare.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // Which bus serves a fetch slot
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PRI  = 2'd1,
    RT_ALT  = 2'd2
  } route_e;
endpackage

// File: rtl/fetch_timer.sv
// Oscillator-clock position inside a two-slot machine cycle.
module fetch_timer #(
  parameter int SLOT_CLKS = 6,
  localparam int SUB_W = $clog2(SLOT_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SUB_W-1:0] sub_o,      // clock within the slot
  output logic             half_o,     // 1 in the second slot
  output logic             slot_end_o, // last clock of a slot
  output logic             cyc_end_o   // last clock of a machine cycle
);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(SLOT_CLKS - 1);

  logic [SUB_W-1:0] sub_q;
  logic             half_q;

  // Reset parks on the final clock so the first edge opens a cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= LAST;
      half_q <= 1'b1;
    end else if (sub_q == LAST) begin
      sub_q  <= '0;
      half_q <= ~half_q;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign sub_o      = sub_q;
  assign half_o     = half_q;
  assign slot_end_o = (sub_q == LAST);
  assign cyc_end_o  = (sub_q == LAST) && half_q;
endmodule

// File: rtl/route_decoder.sv
// Chooses the bus for one fetch from the pin levels and the address.
module route_decoder
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SPLIT_ADDR = 16'h2000
) (
  input  logic              bus_sel_i,
  input  logic              ext_acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output route_e            route_o
);
  always_comb begin
    unique case ({bus_sel_i, ext_acc_i})
      2'b00:   route_o = RT_PRI;
      2'b01:   route_o = RT_NONE;                 // illegal pin pair
      2'b10:   route_o = RT_ALT;
      default: route_o = (addr_i < SPLIT_ADDR) ? RT_ALT : RT_PRI;
    endcase
  end
endmodule

// File: rtl/bus_port.sv
// One program bus pair: address drive, read strobe and opcode capture.
module bus_port #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOT_CLKS = 6,
  parameter int RD_START  = 2,
  parameter int RD_CLKS   = 3,
  localparam int SUB_W    = $clog2(SLOT_CLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              lo_oe_o,
  output logic              rd_n_o,
  output logic              cap_v_o,
  output logic [DATA_W-1:0] cap_d_o
);
  localparam logic [SUB_W-1:0] RD_FIRST = SUB_W'(RD_START);
  localparam logic [SUB_W-1:0] RD_LAST  = SUB_W'(RD_START + RD_CLKS - 1);

  logic in_strobe;
  assign in_strobe = (sub_i >= RD_FIRST) && (sub_i <= RD_LAST);

  assign hi_o    = active_i ? addr_i[ADDR_W-1 -: DATA_W] : '0;
  assign lo_oe_o = active_i && (sub_i < RD_FIRST);
  assign lo_o    = lo_oe_o ? addr_i[DATA_W-1:0] : '0;
  assign rd_n_o  = !(active_i && in_strobe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v_o <= 1'b0;
      cap_d_o <= '0;
    end else if (active_i && (sub_i == RD_LAST)) begin
      cap_v_o <= 1'b1;
      cap_d_o <= rd_data_i;
    end else begin
      cap_v_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_fetch_seq.sv
module dual_fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOT_CLKS = 6,
  parameter int ALE_CLKS  = 2,
  parameter int RD_START  = 2,
  parameter int RD_CLKS   = 3,
  parameter logic [ADDR_W-1:0] SPLIT_ADDR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              bus_sel_i,
  input  logic              ext_acc_i,
  input  logic              xdata_cyc_i,
  output logic              ale_o,
  output logic              pri_rd_n_o,
  output logic [DATA_W-1:0] pri_hi_o,
  output logic [DATA_W-1:0] pri_lo_o,
  output logic              pri_lo_oe_o,
  input  logic [DATA_W-1:0] pri_lo_i,
  output logic              alt_rd_n_o,
  output logic [DATA_W-1:0] alt_hi_o,
  output logic [DATA_W-1:0] alt_lo_o,
  output logic              alt_lo_oe_o,
  input  logic [DATA_W-1:0] alt_lo_i,
  output logic              op_valid_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam int SUB_W  = $clog2(SLOT_CLKS);
  localparam int N_BUS  = 2;
  localparam logic [SUB_W-1:0] ALE_END = SUB_W'(ALE_CLKS);

  logic [SUB_W-1:0] sub;
  logic             half, slot_end, cyc_end;

  fetch_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .sub_o(sub), .half_o(half),
    .slot_end_o(slot_end), .cyc_end_o(cyc_end)
  );

  route_e dec_route;
  route_decoder #(.ADDR_W(ADDR_W), .SPLIT_ADDR(SPLIT_ADDR)) u_dec (
    .bus_sel_i(bus_sel_i), .ext_acc_i(ext_acc_i), .addr_i(pc_i),
    .route_o(dec_route)
  );

  // Slot context, loaded on the clock edge that opens each slot
  route_e            ctx_route;
  logic              ctx_live;
  logic              xd_q;
  logic [ADDR_W-1:0] ctx_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_route <= RT_NONE;
      ctx_live  <= 1'b0;
      xd_q      <= 1'b0;
      ctx_addr  <= '0;
    end else if (slot_end) begin
      if (cyc_end) begin
        xd_q      <= xdata_cyc_i;
        ctx_live  <= 1'b1;
        ctx_route <= dec_route;
        ctx_addr  <= pc_i;
      end else if (xd_q) begin
        ctx_live  <= 1'b0;       // slot lent to the data access
        ctx_route <= RT_NONE;
      end else begin
        ctx_live  <= 1'b1;
        ctx_route <= dec_route;
        ctx_addr  <= pc_i;
      end
    end
  end

  assign ale_o = ctx_live && (sub < ALE_END);

  logic [DATA_W-1:0] hi_w  [N_BUS];
  logic [DATA_W-1:0] lo_w  [N_BUS];
  logic [DATA_W-1:0] rd_w  [N_BUS];
  logic [DATA_W-1:0] cap_d [N_BUS];
  logic [N_BUS-1:0]  oe_w, rdn_w, cap_v;

  assign rd_w[0] = pri_lo_i;
  assign rd_w[1] = alt_lo_i;

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    localparam route_e MY_ID = (b == 0) ? RT_PRI : RT_ALT;
    bus_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_CLKS(SLOT_CLKS),
      .RD_START(RD_START), .RD_CLKS(RD_CLKS)
    ) u_port (
      .clk(clk), .rst_n(rst_n),
      .active_i(ctx_route == MY_ID), .addr_i(ctx_addr), .sub_i(sub),
      .rd_data_i(rd_w[b]),
      .hi_o(hi_w[b]), .lo_o(lo_w[b]), .lo_oe_o(oe_w[b]), .rd_n_o(rdn_w[b]),
      .cap_v_o(cap_v[b]), .cap_d_o(cap_d[b])
    );
  end

  assign pri_hi_o    = hi_w[0];
  assign pri_lo_o    = lo_w[0];
  assign pri_lo_oe_o = oe_w[0];
  assign pri_rd_n_o  = rdn_w[0];
  assign alt_hi_o    = hi_w[1];
  assign alt_lo_o    = lo_w[1];
  assign alt_lo_oe_o = oe_w[1];
  assign alt_rd_n_o  = rdn_w[1];

  assign op_valid_o = |cap_v;
  assign op_data_o  = cap_v[1] ? cap_d[1] : cap_d[0];
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int RD_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ale_o,
  input logic pri_rd_n_o,
  input logic alt_rd_n_o,
  input logic pri_lo_oe_o,
  input logic op_valid_o
);
  localparam int CW = $clog2(RD_CLKS + 2);
  localparam logic [CW-1:0] RD_LEN = CW'(RD_CLKS);

  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)           low_cnt <= '0;
    else if (!pri_rd_n_o) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  // R2/R4/R5: one bus at a time
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pri_rd_n_o && !alt_rd_n_o));

  p_ale_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_o) |=> ale_o);

  p_ale_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && $past(ale_o)) |=> !ale_o);

  p_rd_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_rd_n_o) |-> (low_cnt == RD_LEN));

  p_oe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_rd_n_o) |-> (!pri_lo_oe_o && $past(pri_lo_oe_o)));

  p_op_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> ($rose(pri_rd_n_o) || $rose(alt_rd_n_o)));
endmodule

bind dual_fetch_seq fetch_seq_chk #(.RD_CLKS(RD_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_o(ale_o), .pri_rd_n_o(pri_rd_n_o),
  .alt_rd_n_o(alt_rd_n_o), .pri_lo_oe_o(pri_lo_oe_o), .op_valid_o(op_valid_o)
);

// File: tb/dual_fetch_seq_tb.sv
`timescale 1ns/1ps
module dual_fetch_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] pc = 16'h0;
  logic bsel = 1'b0, eacc = 1'b0, xdc = 1'b0;
  logic ale, prdn, ardn, poe, aoe, opv;
  logic [7:0] phi, plo, ahi, alo, opd, pin, ain;
  logic [7:0] lat_p = 8'h0, lat_a = 8'h0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .bus_sel_i(bsel), .ext_acc_i(eacc),
    .xdata_cyc_i(xdc), .ale_o(ale),
    .pri_rd_n_o(prdn), .pri_hi_o(phi), .pri_lo_o(plo), .pri_lo_oe_o(poe), .pri_lo_i(pin),
    .alt_rd_n_o(ardn), .alt_hi_o(ahi), .alt_lo_o(alo), .alt_lo_oe_o(aoe), .alt_lo_i(ain),
    .op_valid_o(opv), .op_data_o(opd)
  );

  function automatic logic [7:0] mem_p(input logic [15:0] a);
    return (a[15:8] * 8'd3 + a[7:0]) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] mem_a(input logic [15:0] a);
    return ~(a[7:0] + {a[14:8], a[15]}) ^ 8'h3C;
  endfunction

  // External address latches and memories
  always @(posedge clk) begin
    if (ale && poe) lat_p <= plo;
    if (ale && aoe) lat_a <= alo;
  end
  assign pin = !prdn ? mem_p({phi, lat_p}) : 8'hEE;
  assign ain = !ardn ? mem_a({ahi, lat_a}) : 8'hDD;

  // Reference model: 0 none, 1 primary, 2 alternate
  function automatic int pick(input logic s, input logic e, input logic [15:0] a);
    if (!s && !e) return 1;
    if (!s &&  e) return 0;
    if ( s && !e) return 2;
    return (a <= 16'h1FFF) ? 2 : 1;
  endfunction
  function automatic string mode_tag(input logic s, input logic e);
    case ({s, e}) 2'b00: return "R2"; 2'b01: return "R3"; 2'b10: return "R4"; default: return "R5"; endcase
  endfunction

  int m_ph = 11, m_rt = 0;
  logic m_live = 0, m_xd = 0;
  logic [15:0] m_a = 0;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 11; m_rt <= 0; m_live <= 0; m_xd <= 0; m_tag <= "R1";
    end else begin
      m_ph <= (m_ph + 1) % 12;
      if (m_ph == 11) begin
        m_xd <= xdc; m_live <= 1; m_rt <= pick(bsel, eacc, pc); m_a <= pc;
        m_tag <= mode_tag(bsel, eacc);
      end else if (m_ph == 5) begin
        if (m_xd) begin m_live <= 0; m_rt <= 0; m_tag <= "R8"; end
        else begin m_live <= 1; m_rt <= pick(bsel, eacc, pc); m_a <= pc; m_tag <= mode_tag(bsel, eacc); end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int sb;
      logic e_ale;
      sb = m_ph % 6;
      if (!rst_n) begin
        chk("R1", "reset outputs", {11'd0, ale, prdn, ardn, poe, aoe}, {11'd0, 5'b01100});
        chk("R1", "reset valid", {15'd0, opv}, 16'd0);
      end else begin
        e_ale = m_live && sb < 2;
        chk((m_ph >= 6 && m_xd) ? "R9" : "R10", "ale", {15'd0, ale}, {15'd0, e_ale});
        chk((m_ph >= 6 && m_xd) ? "R8" : "R10", "pri strobe", {15'd0, prdn},
            {15'd0, !(m_rt == 1 && sb >= 2 && sb <= 4)});
        chk(m_tag, "alt strobe", {15'd0, ardn}, {15'd0, !(m_rt == 2 && sb >= 2 && sb <= 4)});
        chk("R6", "pri hi/oe", {phi, 7'd0, poe}, {(m_rt == 1) ? m_a[15:8] : 8'h00, 7'd0, (m_rt == 1 && sb < 2)});
        chk("R6", "alt hi/oe", {ahi, 7'd0, aoe}, {(m_rt == 2) ? m_a[15:8] : 8'h00, 7'd0, (m_rt == 2 && sb < 2)});
        if (poe) chk("R6", "pri lo", {8'd0, plo}, {8'd0, m_a[7:0]});
        if (aoe) chk("R6", "alt lo", {8'd0, alo}, {8'd0, m_a[7:0]});
        chk("R7", "op valid", {15'd0, opv}, {15'd0, (m_rt != 0 && sb == 5)});
        if (m_rt != 0 && sb == 5)
          chk(m_tag == "R5" ? "R5" : "R7", "op data", {8'd0, opd},
              {8'd0, (m_rt == 1) ? mem_p(m_a) : mem_a(m_a)});
      end
    end
  end

  task automatic hold(input logic s, input logic e, input logic x, input logic [15:0] a, input int n);
    @(negedge clk);
    bsel = s; eacc = e; xdc = x; pc = a;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    logic [15:0] corner [6];
    corner = '{16'h0000, 16'h1FFF, 16'h2000, 16'hFFFF, 16'h1234, 16'hABCD};
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int x = 0; x < 2; x++)
        for (int i = 0; i < 6; i++)
          hold(m[1], m[0], x[0], corner[i], 12);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pc = $urandom();
      if (($urandom() % 8) == 0) begin bsel = $urandom(); eacc = $urandom(); end
      xdc = (($urandom() % 4) == 0);
      if (($urandom() % 3) == 0) pc = 16'h1FF0 + 16'($urandom() % 32);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule